// File: doc/BRIEF.md
# Pipelined Load/Store Unit with Split Double-Word Beats

This unit sits between a 32-bit register file port and a 32-bit on-chip memory bus. Each cycle it can take one memory operation, described by a size, a direction, a signedness flag and the choice between a register or a 16-bit immediate offset. It then adds the offset to a base operand, or to zero when the base is deselected. The result is issued as a bus request through a valid/ready handshake. Read data coming back from the bus is moved down from its big-endian byte lane, then zero- or sign-extended and returned as a 32-bit writeback.

A double-word operation becomes two 32-bit beats in ascending address order. For a load it produces two writebacks; the second one carries a last flag. While the bus stalls, the pending request is held unchanged and no new operation is taken. Bus read data is expected in the cycle after a read beat is accepted.

Top module: `lsu_core`

## Requirements
- R1: The effective address is (op_base_zero ? 0 : base_val) plus either index_val (op_use_imm = 0) or imm16 sign-extended to 32 bits (op_use_imm = 1), taken modulo 2^32, and it appears on bus_addr for the first beat.
- R2: With bus_ready held high, a byte, half or word load accepted at clock edge k shows wb_valid from edge k+2 for exactly one cycle, with wb_last = 1.
- R3: op_size = 3 (double) issues two beats, at the effective address and then at that address plus 4, each with bus_be = 4'b1111. A store sends st_data[63:32] first and st_data[31:0] second. A load returns the two words in beat order, wb_last = 0 then 1, the last one at edge k+3 when bus_ready is high.
- R4: A byte load (op_size = 0) returns the byte at address offset a[1:0] in bit lane 31-8*a[1:0] to 24-8*a[1:0] of bus_rdata, zero-filled, whatever op_signed is.
- R5: A half-word load (op_size = 1) returns bus_rdata[31:16] when a[1] = 0 and bus_rdata[15:0] when a[1] = 1. It is sign-extended when op_signed = 1 and zero-filled otherwise. A word load (op_size = 2) returns bus_rdata unchanged.
- R6: Every beat sets bus_we = op_store. bus_be is 4'b1000 >> a[1:0] for bytes, 4'b1100 or 4'b0011 (a[1] = 0 or 1) for halves, and 4'b1111 otherwise. Store data is the byte replicated to all four lanes, the half replicated twice, or the word.
- R7: While bus_valid is high and bus_ready low, bus_addr, bus_we, bus_be and bus_wdata stay stable, bus_valid stays high, and in_ready is low.
- R8: With bus_ready high, in_ready is high on every cycle, so one operation is taken per clock. The one exception is the cycle that presents the first beat of a double-word, where in_ready is low.
- R9: During and right after reset, bus_valid and wb_valid are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The operation is taken on this edge |
| op_size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| op_store | input | 1 | 1 store, 0 load |
| op_signed | input | 1 | Sign-extend half-word loads |
| op_use_imm | input | 1 | Offset is imm16 instead of index_val |
| op_base_zero | input | 1 | Use zero instead of base_val |
| base_val | input | 32 | Base register operand |
| index_val | input | 32 | Index register operand |
| imm16 | input | 16 | Signed immediate offset |
| st_data | input | 64 | Store data, low bits for short sizes, high word first for double |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus accepts the request on this edge |
| bus_addr | output | 32 | Byte address of the beat |
| bus_we | output | 1 | Write beat |
| bus_be | output | 4 | Byte enables, bit 3 = lowest address |
| bus_wdata | output | 32 | Write data, big-endian lanes |
| bus_rdata | input | 32 | Read data, valid the cycle after a read beat is accepted |
| wb_valid | output | 1 | Writeback data valid |
| wb_data | output | 32 | Aligned and extended load data |
| wb_last | output | 1 | Final writeback of the operation |

## Verification
The assertions take for granted that the bus returns read data exactly one cycle after it accepts a read, and never later. They also assume that word and double-word addresses are 4-byte aligned and half-word addresses 2-byte aligned, since misalignment is not handled. The stimulus picks an aligned target address first and then derives base_val from it and the chosen offset. When the base is deselected, the offset itself is masked to the alignment. bus_ready is toggled at random but never withdraws data that was already accepted. The memory model answers every accepted read on the following cycle.

// File: rtl/lsu_core.sv
module lsu_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [1:0]  op_size,
  input  logic        op_store,
  input  logic        op_signed,
  input  logic        op_use_imm,
  input  logic        op_base_zero,
  input  logic [31:0] base_val,
  input  logic [31:0] index_val,
  input  logic [15:0] imm16,
  input  logic [63:0] st_data,
  output logic        bus_valid,
  input  logic        bus_ready,
  output logic [31:0] bus_addr,
  output logic        bus_we,
  output logic [3:0]  bus_be,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  output logic        wb_valid,
  output logic [31:0] wb_data,
  output logic        wb_last
);

  logic        rq_valid, rq_we, rq_first, rq_signed;
  logic [1:0]  rq_size;
  logic [31:0] rq_addr, rq_wdata, rq_lo;
  logic [3:0]  rq_be;

  logic        rs_valid, rs_signed, rs_last;
  logic [1:0]  rs_size, rs_off;

  logic [31:0] ea, lane_word, ld_word;
  logic [15:0] half_sel;
  logic        take, fire;

  assign ea   = (op_base_zero ? 32'd0 : base_val) +
                (op_use_imm ? {{16{imm16[15]}}, imm16} : index_val);
  assign fire = rq_valid && bus_ready;
  assign in_ready = !rq_valid || (bus_ready && !rq_first);
  assign take = in_valid && in_ready;

  assign bus_valid = rq_valid;
  assign bus_addr  = rq_addr;
  assign bus_we    = rq_we;
  assign bus_be    = rq_be;
  assign bus_wdata = rq_wdata;

  function automatic logic [3:0] lanes(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'd0:    lanes = 4'b1000 >> off;
      2'd1:    lanes = off[1] ? 4'b0011 : 4'b1100;
      default: lanes = 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] place(input logic [1:0] sz, input logic [63:0] d);
    case (sz)
      2'd0:    place = {4{d[7:0]}};
      2'd1:    place = {2{d[15:0]}};
      2'd2:    place = d[31:0];
      default: place = d[63:32];
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq_valid  <= 1'b0;
      rq_first  <= 1'b0;
      rq_we     <= 1'b0;
      rq_signed <= 1'b0;
      rq_size   <= 2'd0;
      rq_addr   <= 32'd0;
      rq_wdata  <= 32'd0;
      rq_lo     <= 32'd0;
      rq_be     <= 4'd0;
    end else if (fire && rq_first) begin
      rq_addr  <= rq_addr + 32'd4;
      rq_wdata <= rq_lo;
      rq_first <= 1'b0;
    end else if (take) begin
      rq_valid  <= 1'b1;
      rq_addr   <= ea;
      rq_we     <= op_store;
      rq_signed <= op_signed;
      rq_size   <= op_size;
      rq_first  <= (op_size == 2'd3);
      rq_be     <= lanes(op_size, ea[1:0]);
      rq_wdata  <= place(op_size, st_data);
      rq_lo     <= st_data[31:0];
    end else if (fire) begin
      rq_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid  <= 1'b0;
      rs_signed <= 1'b0;
      rs_last   <= 1'b0;
      rs_size   <= 2'd0;
      rs_off    <= 2'd0;
    end else begin
      rs_valid  <= fire && !rq_we;
      rs_signed <= rq_signed;
      rs_last   <= !rq_first;
      rs_size   <= rq_size;
      rs_off    <= rq_addr[1:0];
    end
  end

  assign lane_word = bus_rdata >> {~rs_off, 3'b000};
  assign half_sel  = rs_off[1] ? bus_rdata[15:0] : bus_rdata[31:16];

  always_comb begin
    case (rs_size)
      2'd0:    ld_word = {24'd0, lane_word[7:0]};
      2'd1:    ld_word = {{16{rs_signed & half_sel[15]}}, half_sel};
      default: ld_word = bus_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_data  <= 32'd0;
      wb_last  <= 1'b0;
    end else begin
      wb_valid <= rs_valid;
      if (rs_valid) begin
        wb_data <= ld_word;
        wb_last <= rs_last;
      end
    end
  end

endmodule

// File: rtl/lsu_core_chk.sv
module lsu_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        bus_valid,
  input logic        bus_ready,
  input logic [31:0] bus_addr,
  input logic        bus_we,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic        wb_valid,
  input logic        rq_first
);

  // R7
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we) &&
                                $stable(bus_be) && $stable(bus_wdata));

  // R7
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |-> !in_ready);

  // R3
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && rq_first |=> bus_valid && bus_be == 4'hF &&
                                            bus_addr == $past(bus_addr) + 32'd4);

  // R2
  wb_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(bus_valid && bus_ready && !bus_we, 2));

  // R6
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2 ||
                   $countones(bus_be) == 4));

  // R8
  first_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && rq_first |-> !in_ready);

endmodule

bind lsu_core lsu_core_chk u_chk (.*);

// File: tb/lsu_core_bench.sv
`timescale 1ns/1ps
module lsu_core_bench;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [1:0]  op_size = 2'd0;
  logic        op_store = 1'b0, op_signed = 1'b0, op_use_imm = 1'b0, op_base_zero = 1'b0;
  logic [31:0] base_val = 32'd0, index_val = 32'd0;
  logic [15:0] imm16 = 16'd0;
  logic [63:0] st_data = 64'd0;
  logic        bus_valid, bus_ready = 1'b1, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = 32'd0;
  logic [3:0]  bus_be;
  logic        wb_valid, wb_last;
  logic [31:0] wb_data;

  lsu_core u_lsu_core (.*);

  always #4 clk = ~clk;

  typedef struct {logic [31:0] addr; logic we; logic [3:0] be; logic [31:0] wdata;
                  logic [1:0] size; logic sgn; logic last;} beat_t;
  typedef struct {logic [31:0] data; logic last; int due;} wbx_t;
  beat_t bq[$];
  wbx_t  wq[$];

  int checks = 0, fails = 0, n = 0, acc_n = 0, last_wb_n = 0;
  bit acc_flag = 0, rnd_ready = 0, done = 0, hold_chk = 0;
  logic [31:0] h_addr, h_wdata;
  logic [3:0]  h_be;
  logic        h_we;

  function automatic logic [31:0] mem(input logic [31:0] a);
    return ({a[31:2], 2'b00} * 32'h9E3779B1) ^ 32'h5A5A_1234;
  endfunction

  function automatic logic [31:0] exp_load(input logic [31:0] w, input logic [1:0] sz,
                                           input logic sgn, input logic [1:0] off);
    logic [7:0] b;
    logic [15:0] h;
    b = w[8*(3-off) +: 8];
    h = (off == 2'd2) ? w[15:0] : w[31:16];
    case (sz)
      2'd0: return {24'd0, b};
      2'd1: return sgn ? {{16{h[15]}}, h} : {16'd0, h};
      default: return w;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push_op();
    beat_t b;
    logic [31:0] ea;
    ea = (op_base_zero ? 32'd0 : base_val) + (op_use_imm ? {{16{imm16[15]}}, imm16} : index_val);
    b.we = op_store; b.size = op_size; b.sgn = op_signed; b.addr = ea;
    case (op_size)
      2'd0: begin b.be = 4'b1000 >> ea[1:0]; b.wdata = {4{st_data[7:0]}}; end
      2'd1: begin b.be = ea[1] ? 4'b0011 : 4'b1100; b.wdata = {2{st_data[15:0]}}; end
      2'd2: begin b.be = 4'hF; b.wdata = st_data[31:0]; end
      default: begin b.be = 4'hF; b.wdata = st_data[63:32]; end
    endcase
    b.last = (op_size != 2'd3);
    bq.push_back(b);
    if (op_size == 2'd3) begin
      b.addr = ea + 32'd4; b.wdata = st_data[31:0]; b.last = 1'b1;
      bq.push_back(b);
    end
  endtask

  task automatic tick();
    bit pend;
    logic [31:0] paddr;
    beat_t b;
    wbx_t w;
    #1;
    n++;
    pend = 0; paddr = 32'd0;
    if (hold_chk)
      chk(bus_valid && bus_addr == h_addr && bus_be == h_be && bus_we == h_we && bus_wdata == h_wdata,
          "R7", "held request", {bus_addr, bus_wdata}, {h_addr, h_wdata});
    hold_chk = bus_valid && !bus_ready;
    h_addr = bus_addr; h_be = bus_be; h_we = bus_we; h_wdata = bus_wdata;
    if (bus_valid && !bus_ready) chk(!in_ready, "R7", "in_ready under stall", 64'(in_ready), 64'd0);
    acc_flag = in_valid && in_ready;
    if (acc_flag) begin push_op(); acc_n = n; end
    if (bus_valid && bus_ready) begin
      if (bq.size() == 0) chk(0, "R6", "unexpected beat", {32'd0, bus_addr}, 64'd0);
      else begin
        b = bq.pop_front();
        chk(bus_addr == b.addr, b.last && b.size == 2'd3 ? "R3" : "R1", "beat address",
            64'(bus_addr), 64'(b.addr));
        chk(bus_we == b.we && bus_be == b.be, "R6", "we/be", {bus_we, bus_be}, {b.we, b.be});
        if (b.we) chk(bus_wdata == b.wdata, b.size == 2'd3 ? "R3" : "R6", "write data",
                      64'(bus_wdata), 64'(b.wdata));
        else begin
          pend = 1; paddr = bus_addr;
          w.data = exp_load(mem(bus_addr), b.size, b.sgn, b.addr[1:0]);
          w.last = b.last; w.due = n + 2;
          wq.push_back(w);
        end
      end
    end
    if (wb_valid) begin
      if (wq.size() == 0) chk(0, "R2", "unexpected writeback", 64'(wb_data), 64'd0);
      else begin
        w = wq.pop_front();
        chk(wb_data == w.data, "R4", "R5 load data", 64'(wb_data), 64'(w.data));
        chk(wb_last == w.last && n == w.due, "R3", "last flag / timing", {wb_last, 32'(n)},
            {w.last, 32'(w.due)});
        if (wb_last) last_wb_n = n;
      end
    end else if (wq.size() != 0 && wq[0].due == n)
      chk(0, "R2", "missing writeback", 64'd0, 64'(wq[0].data));
    @(posedge clk);
    @(negedge clk);
    bus_rdata = pend ? mem(paddr) : $urandom();
    if (rnd_ready) bus_ready = ($urandom_range(3) != 0);
  endtask

  task automatic set_op(input logic [1:0] sz, input bit st, input bit sg, input bit ui,
                        input bit bz, input logic [31:0] target);
    logic [31:0] off;
    logic [1:0] m;
    m = (sz == 2'd0) ? 2'b00 : (sz == 2'd1) ? 2'b01 : 2'b11;
    op_size = sz; op_store = st; op_signed = sg; op_use_imm = ui; op_base_zero = bz;
    imm16 = $urandom(); index_val = $urandom(); base_val = $urandom();
    st_data = {$urandom(), $urandom()};
    if (bz) begin
      imm16[1:0] = imm16[1:0] & ~m;
      index_val[1:0] = index_val[1:0] & ~m;
    end else begin
      off = ui ? {{16{imm16[15]}}, imm16} : index_val;
      base_val = {target[31:2], target[1:0] & ~m} - off;
    end
  endtask

  task automatic issue();
    in_valid = 1'b1;
    do tick(); while (!acc_flag);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  initial begin
    int a;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!bus_valid && !wb_valid && in_ready, "R9", "reset outputs",
        {bus_valid, wb_valid, in_ready}, 64'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_valid && !wb_valid && in_ready, "R9", "after reset", {bus_valid, wb_valid, in_ready}, 64'b001);

    // R1: zero base with negative immediate; base_val is garbage
    set_op(2'd2, 0, 0, 1, 1, 0); imm16 = 16'hFF00; base_val = 32'hDEAD_BEE0;
    issue(); a = acc_n; idle(5);
    chk(last_wb_n - a == 3, "R2", "word load latency", 64'(last_wb_n - a), 64'd3);
    set_op(2'd3, 0, 0, 0, 0, 32'h0000_1008);
    issue(); a = acc_n; idle(6);
    chk(last_wb_n - a == 4, "R3", "double load latency", 64'(last_wb_n - a), 64'd4);
    // R3/R8: double followed at once by a word, second accepted two ticks later
    set_op(2'd3, 1, 0, 1, 0, 32'h0000_2000); issue(); a = acc_n;
    set_op(2'd2, 0, 0, 1, 0, 32'h0000_2040); issue();
    chk(acc_n - a == 2, "R8", "accept after double", 64'(acc_n - a), 64'd2);
    idle(4);
    // R4 / R5: every byte lane and both half lanes, signed and unsigned
    for (int o = 0; o < 4; o++) begin
      set_op(2'd0, 0, o[0], 1, 0, 32'h0000_3000 + 32'(o)); issue();
    end
    for (int o = 0; o < 4; o++) begin
      set_op(2'd1, 0, o[0], 0, 0, 32'h8000_4000 + 32'(o[1] * 2)); issue();
    end
    for (int o = 0; o < 4; o++) begin
      set_op(2'd0, 1, 0, 0, 0, 32'h0000_5000 + 32'(o)); issue();
    end
    set_op(2'd1, 1, 0, 0, 0, 32'h0000_5002); issue();
    idle(4);
    // R8: back-to-back burst
    a = 0;
    for (int i = 0; i < 8; i++) begin
      set_op(2'd2, 0, 0, 1, 0, 32'h0000_6000 + 32'(i * 4));
      in_valid = 1'b1; tick(); if (acc_flag) a++;
    end
    in_valid = 1'b0;
    chk(a == 8, "R8", "burst accepts", 64'(a), 64'd8);
    idle(4);
    // random phase with back-pressure (R7)
    rnd_ready = 1;
    for (int i = 0; i < 3000; i++) begin
      set_op(2'($urandom_range(3)), $urandom_range(1), $urandom_range(1), $urandom_range(1),
             ($urandom_range(3) == 0), $urandom());
      issue();
      if ($urandom_range(3) == 0) idle($urandom_range(2));
    end
    rnd_ready = 0; bus_ready = 1'b1;
    idle(8);
    chk(bq.size() == 0 && wq.size() == 0, "R3", "queues drained", 64'(bq.size() + wq.size()), 64'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule